// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This unit sits between one processor and a single-ported shared memory. It runs an atomic operation on one memory word for the processor: swap, test-and-set, fetch-and-increment, or a plain read. The processor issues one request and receives one response. Inside, the unit reads the word in one phase and writes the new value in a later phase.

Between the two phases, other agents may try to write or invalidate memory through a separate snoop channel. The unit holds back any snoop aimed at the word it is working on. It keeps it held back until the write phase has finished. Snoops to other words are accepted at once.

For lock use, a word of 0 means free and 1 means held. A test-and-set that returns 0 has taken the lock. A return of 1 means another agent already held it.

Top module: `amo_xchg_unit`

## Requirements
- R1: `req_op` is a 2-bit code (00 swap, 01 test-and-set, 10 fetch-and-increment, 11 plain read). For a swap, the response carries the word held before the request, and the word then holds `req_wdata`.
- R2: A test-and-set returns the old word. If the old word was 0, the word then holds 1. If it was nonzero, the memory is not written at all.
- R3: A fetch-and-increment returns the old word and stores that word plus one.
- R4: A fetch-and-increment of the all-ones word returns all-ones and stores zero.
- R5: A plain read (code 11) returns the word and makes no memory write.
- R6: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. The read access is issued in the next cycle. Any write goes to the same address two cycles after the read. `rsp_valid` is high for exactly one cycle, four cycles after acceptance, whatever the opcode.
- R7: From the cycle after acceptance through the write-phase cycle, `snp_ready` is low whenever `snp_valid` is high and `snp_addr` matches the locked address. In the response cycle it is high again.
- R8: A snoop to a different address, or any snoop while no operation is in flight, sees `snp_ready` high.
- R9: `req_ready` is low from the cycle after acceptance through the response cycle. It is high again in the cycle after the response.
- R10: During and right after reset, `req_ready` is high, and `rsp_valid` and `mem_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Unit can accept a request |
| req_op | input | 2 | Operation code |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Operand for swap |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | DW | Word value before the operation |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Read data, valid one cycle after a read access |
| snp_valid | input | 1 | External write or invalidate request present |
| snp_addr | input | AW | Address of the external request |
| snp_ready | output | 1 | External request may proceed |

## Verification
The assertions assume two things about the memory: it returns read data exactly one cycle after a read access, and it takes a write on the edge where `mem_en` and `mem_we` are high. They also assume that the processor keeps its request fields stable while `req_valid` is high and that it never raises a request while `req_ready` is low. The stimulus follows these rules. A memory model in the bench has fixed one-cycle read latency. Requests are driven only in cycles where `req_ready` is expected high. Snoop requests are driven freely in every phase, to the locked address and to other addresses, because the unit must handle any snoop pattern.

// File: rtl/amo_pkg.sv
package amo_pkg;

   typedef enum logic [1:0] {
      AMO_SWAP = 2'b00,
      AMO_TSET = 2'b01,
      AMO_FINC = 2'b10,
      AMO_READ = 2'b11
   } amo_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_CAPT,
      ST_STORE,
      ST_REPLY
   } amo_state_e;

endpackage

// File: rtl/amo_calc.sv
module amo_calc
   import amo_pkg::*;
#(
   parameter int DW = 32
) (
   input  amo_op_e         op,
   input  logic [DW-1:0]   old_word,
   input  logic [DW-1:0]   operand,
   output logic [DW-1:0]   new_word,
   output logic            do_write
);

   localparam logic [DW-1:0] ONE  = DW'(1);
   localparam logic [DW-1:0] ZERO = '0;

   if (DW < 1) begin : g_bad_dw
      $error("amo_calc: DW must be at least 1");
   end

   always_comb begin
      new_word = old_word;
      do_write = 1'b0;
      unique case (op)
         AMO_SWAP: begin
            new_word = operand;
            do_write = 1'b1;
         end
         AMO_TSET: begin
            new_word = ONE;
            do_write = (old_word == ZERO);
         end
         AMO_FINC: begin
            new_word = old_word + ONE;
            do_write = 1'b1;
         end
         default: begin
            new_word = old_word;
            do_write = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/amo_hold_gate.sv
module amo_hold_gate #(
   parameter int AW        = 16,
   parameter int MATCH_LSB = 0
) (
   input  logic           lock_active,
   input  logic [AW-1:0]  lock_addr,
   input  logic           snp_valid,
   input  logic [AW-1:0]  snp_addr,
   output logic           snp_ready
);

   logic hit;

   if (MATCH_LSB < 0 || MATCH_LSB >= AW) begin : g_bad_lsb
      $error("amo_hold_gate: MATCH_LSB must lie in 0..AW-1");
   end

   if (MATCH_LSB == 0) begin : g_word_match
      assign hit = (lock_addr == snp_addr);
   end else begin : g_block_match
      assign hit = (lock_addr[AW-1:MATCH_LSB] == snp_addr[AW-1:MATCH_LSB]);
   end

   assign snp_ready = !(snp_valid && lock_active && hit);

endmodule

// File: rtl/amo_xchg_unit.sv
module amo_xchg_unit
   import amo_pkg::*;
#(
   parameter int AW        = 16,
   parameter int DW        = 32,
   parameter int MATCH_LSB = 0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req_valid,
   output logic           req_ready,
   input  logic [1:0]     req_op,
   input  logic [AW-1:0]  req_addr,
   input  logic [DW-1:0]  req_wdata,
   output logic           rsp_valid,
   output logic [DW-1:0]  rsp_data,
   output logic           mem_en,
   output logic           mem_we,
   output logic [AW-1:0]  mem_addr,
   output logic [DW-1:0]  mem_wdata,
   input  logic [DW-1:0]  mem_rdata,
   input  logic           snp_valid,
   input  logic [AW-1:0]  snp_addr,
   output logic           snp_ready
);

   if (AW < 1) begin : g_bad_aw
      $error("amo_xchg_unit: AW must be at least 1");
   end

   amo_state_e       state_q;
   amo_op_e          op_q;
   logic [AW-1:0]    addr_q;
   logic [DW-1:0]    opnd_q;
   logic [DW-1:0]    old_q;
   logic [DW-1:0]    new_word;
   logic             need_write;
   logic             lock_active;
   logic             accept;

   assign accept      = req_valid && req_ready;
   assign req_ready   = (state_q == ST_IDLE);
   assign lock_active = (state_q == ST_LOAD) || (state_q == ST_CAPT) ||
                        (state_q == ST_STORE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_q    <= AMO_READ;
         addr_q  <= '0;
         opnd_q  <= '0;
         old_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (accept) begin
               op_q    <= amo_op_e'(req_op);
               addr_q  <= req_addr;
               opnd_q  <= req_wdata;
               state_q <= ST_LOAD;
            end
            ST_LOAD:  state_q <= ST_CAPT;
            ST_CAPT: begin
               old_q   <= mem_rdata;
               state_q <= ST_STORE;
            end
            ST_STORE: state_q <= ST_REPLY;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   amo_calc #(.DW(DW)) u_calc (
      .op       (op_q),
      .old_word (old_q),
      .operand  (opnd_q),
      .new_word (new_word),
      .do_write (need_write)
   );

   amo_hold_gate #(.AW(AW), .MATCH_LSB(MATCH_LSB)) u_gate (
      .lock_active (lock_active),
      .lock_addr   (addr_q),
      .snp_valid   (snp_valid),
      .snp_addr    (snp_addr),
      .snp_ready   (snp_ready)
   );

   assign mem_we    = (state_q == ST_STORE) && need_write;
   assign mem_en    = (state_q == ST_LOAD) || mem_we;
   assign mem_addr  = addr_q;
   assign mem_wdata = new_word;
   assign rsp_valid = (state_q == ST_REPLY);
   assign rsp_data  = old_q;

   // R6: a store is always preceded, two cycles earlier, by a load
   a_r6_store_after_load: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && mem_we) |-> $past(mem_en && !mem_we, 2));

   // R6: store targets the address that was loaded
   a_r6_store_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && mem_we) |-> (mem_addr == $past(mem_addr, 2)));

   // R9: one outstanding operation
   a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R9: ready returns right after the response
   a_r9_ready_after_reply: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> req_ready);

   // R7: no snoop to the locked word passes during the sequence
   a_r7_hold_locked_word: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && snp_ready && lock_active) |->
      ((snp_addr >> MATCH_LSB) != (addr_q >> MATCH_LSB)));

   // R2: test-and-set only ever stores the value one
   a_r2_tset_stores_one: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && mem_we && op_q == AMO_TSET) |-> (mem_wdata == DW'(1)));

endmodule

// File: tb/amo_xchg_unit_test.sv
`timescale 1ns/1ps
module amo_xchg_unit_test;

   localparam int AW = 4;
   localparam int DW = 8;
   localparam int NW = 1 << AW;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           req_valid = 1'b0;
   logic           req_ready;
   logic [1:0]     req_op = 2'b11;
   logic [AW-1:0]  req_addr = '0;
   logic [DW-1:0]  req_wdata = '0;
   logic           rsp_valid;
   logic [DW-1:0]  rsp_data;
   logic           mem_en;
   logic           mem_we;
   logic [AW-1:0]  mem_addr;
   logic [DW-1:0]  mem_wdata;
   logic [DW-1:0]  mem_rdata;
   logic           snp_valid = 1'b0;
   logic [AW-1:0]  snp_addr = '0;
   logic           snp_ready;

   logic [DW-1:0]  ram [NW];
   logic [DW-1:0]  ref_mem [NW];
   int             wr_cnt = 0;
   int             n_checks = 0;
   int             n_fail = 0;

   always #4 clk = ~clk;

   amo_xchg_unit #(.AW(AW), .DW(DW), .MATCH_LSB(0)) uut (
      .clk, .rst_n, .req_valid, .req_ready, .req_op, .req_addr, .req_wdata,
      .rsp_valid, .rsp_data, .mem_en, .mem_we, .mem_addr, .mem_wdata,
      .mem_rdata, .snp_valid, .snp_addr, .snp_ready
   );

   function automatic logic [DW-1:0] init_val(int i);
      return DW'(i * 37 + 3);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NW; i++) ram[i] <= init_val(i);
         mem_rdata <= '0;
      end else if (mem_en && mem_we) begin
         ram[mem_addr] <= mem_wdata;
         wr_cnt <= wr_cnt + 1;
      end else if (mem_en) begin
         mem_rdata <= ram[mem_addr];
      end
   end

   function automatic bit exp_writes(logic [1:0] op, logic [DW-1:0] old);
      case (op)
         2'b00:   return 1'b1;
         2'b01:   return (old == '0);
         2'b10:   return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [DW-1:0] exp_next(logic [1:0] op, logic [DW-1:0] old,
                                              logic [DW-1:0] opnd);
      case (op)
         2'b00:   return opnd;
         2'b01:   return (old == '0) ? DW'(1) : old;
         2'b10:   return old + DW'(1);
         default: return old;
      endcase
   endfunction

   function automatic string op_tag(logic [1:0] op, logic [DW-1:0] old);
      case (op)
         2'b00:   return "R1";
         2'b01:   return "R2";
         2'b10:   return (old == '1) ? "R4" : "R3";
         default: return "R5";
      endcase
   endfunction

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // snp_mode: 0 none, 1 same address, 2 other address
   task automatic run_op(logic [1:0] op, logic [AW-1:0] addr, logic [DW-1:0] opnd,
                         int snp_mode);
      logic [DW-1:0] old;
      logic [AW-1:0] other;
      int            wr_before;
      bit            exp_rdy;
      string         tag;
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = opnd;
      snp_valid = 1'b0;
      check(req_ready == 1'b1, "R9", "ready before request", req_ready, 1);
      old = ref_mem[addr];
      tag = op_tag(op, old);
      wr_before = wr_cnt;
      @(negedge clk);
      req_valid = 1'b0;
      req_op = $urandom_range(3, 0);
      check(req_ready == 1'b0, "R9", "ready after accept", req_ready, 0);
      other = addr ^ AW'($urandom_range(NW - 1, 1));
      if (snp_mode != 0) begin
         snp_valid = 1'b1;
         snp_addr  = (snp_mode == 1) ? addr : other;
      end
      exp_rdy = (snp_mode != 1);
      for (int ph = 1; ph <= 3; ph++) begin
         #1;
         check(snp_ready == exp_rdy, (snp_mode == 1) ? "R7" : "R8",
               "snoop ready in sequence", snp_ready, exp_rdy);
         check(rsp_valid == 1'b0, "R6", "early response", rsp_valid, 0);
         @(negedge clk);
      end
      // response cycle
      check(rsp_valid == 1'b1, "R6", "response strobe", rsp_valid, 1);
      check(rsp_data == old, tag, "returned word", rsp_data, old);
      check(req_ready == 1'b0, "R9", "ready in response cycle", req_ready, 0);
      if (snp_mode != 0)
         check(snp_ready == 1'b1, "R7", "snoop released", snp_ready, 1);
      check((wr_cnt - wr_before) == int'(exp_writes(op, old)), tag, "write count",
            wr_cnt - wr_before, int'(exp_writes(op, old)));
      ref_mem[addr] = exp_next(op, old, opnd);
      check(ram[addr] == ref_mem[addr], tag, "stored word", ram[addr], ref_mem[addr]);
      snp_valid = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < NW; i++) ref_mem[i] = init_val(i);
      repeat (3) @(negedge clk);
      check(req_ready == 1'b1, "R10", "reset req_ready", req_ready, 1);
      check(rsp_valid == 1'b0, "R10", "reset rsp_valid", rsp_valid, 0);
      check(mem_en == 1'b0, "R10", "reset mem_en", mem_en, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1, "R10", "after reset req_ready", req_ready, 1);
      check(mem_en == 1'b0, "R10", "after reset mem_en", mem_en, 0);
      snp_valid = 1'b1; snp_addr = 4'd5;
      #1;
      check(snp_ready == 1'b1, "R8", "idle snoop ready", snp_ready, 1);
      snp_valid = 1'b0;

      // directed corners
      run_op(2'b00, 4'd2, 8'h00, 1);   // R1 swap in a free lock
      run_op(2'b01, 4'd2, 8'h00, 1);   // R2 lock free: acquire
      run_op(2'b01, 4'd2, 8'h00, 2);   // R2 lock held: no write
      run_op(2'b00, 4'd7, 8'hFF, 0);   // R1 swap all-ones in
      run_op(2'b10, 4'd7, 8'h00, 1);   // R4 wrap to zero
      run_op(2'b10, 4'd7, 8'h00, 0);   // R3 zero to one
      run_op(2'b11, 4'd9, 8'hA5, 1);   // R5 plain read
      run_op(2'b00, 4'd2, 8'h00, 2);   // R1 release the lock

      for (int k = 0; k < 300; k++) begin
         logic [1:0]    op;
         logic [AW-1:0] a;
         logic [DW-1:0] d;
         op = $urandom_range(3, 0);
         a  = $urandom_range(NW - 1, 0);
         d  = ($urandom_range(3, 0) == 0) ? DW'(0) : DW'($urandom_range(255, 0));
         run_op(op, a, d, $urandom_range(2, 0));
      end

      @(negedge clk);
      check(req_ready == 1'b1, "R9", "ready after final response", req_ready, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule